// File: doc/BRIEF.md
# Split-Address Early-Lookup Cache Bank

This block is one bank of a large set-associative cache. A lookup's address reaches it in two separate messages. The first travels on a narrow, low-latency channel and carries only the bank select and the set index. The remainder, the tag, follows later on a wide, slower channel. When an early message names this bank, the bank starts reading every way of the indexed set at once. The array latency therefore overlaps the time the tag spends in transit.

After a fixed read latency, the bank holds the tag, the valid bit and the data of all eight ways in registers. It keeps them there until the tag message with the same request ID arrives. It then compares the tag against the held ways and emits one response: hit or miss, the matching way and its data. The bank serves one request at a time. While a request waits for its tag, a cancel input can abandon it. A separate fill port writes a line into the array. If the set already holds that tag, the fill overwrites that way. Otherwise it writes the way named by a rotating victim counter.

Top module: `cb_bank`

## Requirements
- R1: After reset, `lk_ready_o` is 1, `rsp_valid_o` is 0 and every way of every set is invalid.
- R2: An early message whose `lk_bank_i` differs from parameter `BANK_ID` is ignored. `lk_ready_o` stays 1 and no response follows.
- R3: An early message is accepted only while `lk_ready_o` is 1. Acceptance drops `lk_ready_o` to 0 from the next cycle, and early messages offered while it is 0 are dropped.
- R4: A tag message is taken only while a request is pending and only when `tg_id_i` equals the pending request's ID. A tag message with any other ID has no effect.
- R5: If the early message is accepted at clock edge 0 and its tag at edge d (d ≥ 1), `rsp_valid_o` is high in exactly the cycle after edge max(RD_LAT, d)+1. When the tag arrives before the read finishes, the compare waits for the read.
- R6: A hit (`rsp_hit_o`=1) is reported only when a held way is valid and its stored tag equals the received tag. `rsp_way_o` gives that way and `rsp_data_o` gives its data. `rsp_id_o` echoes the request ID.
- R7: On a miss, `rsp_hit_o` is 0, and `rsp_way_o` and `rsp_data_o` are 0.
- R8: Each request yields exactly one response, a one-cycle pulse. `lk_ready_o` is 1 in the response cycle.
- R9: A fill to a set that already holds the same valid tag overwrites that way. Otherwise it writes the way given by a victim counter. The counter starts at 0 and advances by one, modulo 8, on each such allocation only.
- R10: `cancel_i` while a request is pending drops it. No response is produced, and `lk_ready_o` is 1 in the next cycle.
- R11: A tag message arriving while no request is pending is ignored and produces no response.
- R12: The way contents are captured at edge RD_LAT after acceptance. A fill to that set after that edge does not change the pending request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Early (partial address) message valid |
| lk_bank_i | input | 6 | Target bank field |
| lk_index_i | input | 4 | Set index |
| lk_id_i | input | 3 | Request ID |
| lk_ready_o | output | 1 | Bank free to take an early message |
| tg_valid_i | input | 1 | Tag message valid |
| tg_id_i | input | 3 | Request ID of the tag message |
| tg_tag_i | input | 10 | Tag bits |
| cancel_i | input | 1 | Abandon the pending request |
| fill_valid_i | input | 1 | Fill write valid |
| fill_index_i | input | 4 | Fill set index |
| fill_tag_i | input | 10 | Fill tag |
| fill_data_i | input | 32 | Fill data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_id_o | output | 3 | Request ID of the response |
| rsp_hit_o | output | 1 | Hit flag |
| rsp_way_o | output | 3 | Matching way |
| rsp_data_o | output | 32 | Data of the matching way |

## Verification
Two events can land on the same clock edge: completion of the set read and arrival of the tag. The bench provokes this with tag delays before, equal to and after the read latency. It checks that the response comes exactly one cycle after the later of the two and carries the correct hit result.

A fill can also collide with a held read. The bench drives a fill into the set just after the capture edge and expects the pending request to see the old contents. Random fills and lookups over a few sets and a small tag pool then exercise hits, misses and victim rotation against a bench model.

// File: rtl/cb_pkg.sv
package cb_pkg;
  parameter int BANK_W = 6;
  parameter int IDX_W  = 4;
  parameter int TAG_W  = 10;
  parameter int DATA_W = 32;
  parameter int ID_W   = 3;
  parameter int WAYS   = 8;
  localparam int SETS  = 1 << IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  typedef struct packed {
    logic              valid;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } way_ent_t;

  function automatic logic [WAY_W-1:0] first_one(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/cb_array.sv
module cb_array
  import cb_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [TAG_W-1:0]       wr_tag_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [IDX_W-1:0]       rd_idx_i,
  output way_ent_t [WAYS-1:0]    rd_set_o
);
  logic [WAYS-1:0]  wr_match;
  logic [WAY_W-1:0] victim_q;
  logic [WAY_W-1:0] wr_way;
  logic             wr_alloc;

  assign wr_alloc = ~|wr_match;
  assign wr_way   = wr_alloc ? victim_q : first_one(wr_match);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    way_ent_t col [SETS];

    assign wr_match[w] = col[wr_idx_i].valid && (col[wr_idx_i].tag == wr_tag_i);
    assign rd_set_o[w] = col[rd_idx_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) col[s] <= '0;
      end else if (wr_en_i && (wr_way == WAY_W'(w))) begin
        col[wr_idx_i] <= '{valid: 1'b1, tag: wr_tag_i, data: wr_data_i};
      end
    end
  end

  // round-robin victim, advances only when a new line is allocated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  victim_q <= '0;
    else if (wr_en_i && wr_alloc) victim_q <= victim_q + 1'b1;
  end
endmodule

// File: rtl/cb_read_pipe.sv
module cb_read_pipe
  import cb_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                clear_i,
  input  way_ent_t [WAYS-1:0] set_i,
  output logic                done_o,
  output way_ent_t [WAYS-1:0] ways_o
);
  localparam int CNT_W = $clog2(RD_LAT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
      ways_o <= '0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(RD_LAT);
      done_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        ways_o <= set_i;
        done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cb_tag_match.sv
module cb_tag_match
  import cb_pkg::*;
(
  input  way_ent_t [WAYS-1:0] ways_i,
  input  logic [TAG_W-1:0]    tag_i,
  output logic                hit_o,
  output logic [WAY_W-1:0]    way_o,
  output logic [DATA_W-1:0]   data_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = ways_i[w].valid && (ways_i[w].tag == tag_i);
  end

  always_comb begin
    hit_o  = |eq;
    way_o  = hit_o ? first_one(eq) : '0;
    data_o = hit_o ? ways_i[way_o].data : '0;
  end
endmodule

// File: rtl/cb_bank.sv
module cb_bank
  import cb_pkg::*;
#(
  parameter logic [BANK_W-1:0] BANK_ID = 6'h2A,
  parameter int                RD_LAT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [BANK_W-1:0] lk_bank_i,
  input  logic [IDX_W-1:0]  lk_index_i,
  input  logic [ID_W-1:0]   lk_id_i,
  output logic              lk_ready_o,
  input  logic              tg_valid_i,
  input  logic [ID_W-1:0]   tg_id_i,
  input  logic [TAG_W-1:0]  tg_tag_i,
  input  logic              cancel_i,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_index_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              rsp_valid_o,
  output logic [ID_W-1:0]   rsp_id_o,
  output logic              rsp_hit_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic                busy_q, tag_got_q;
  logic [ID_W-1:0]     id_q;
  logic [IDX_W-1:0]    idx_q;
  logic [TAG_W-1:0]    tag_q;
  way_ent_t [WAYS-1:0] set_rd, ways_q;
  logic                rd_done;
  logic                lk_acc, tg_acc, kill, fire;
  logic                mt_hit;
  logic [WAY_W-1:0]    mt_way;
  logic [DATA_W-1:0]   mt_data;

  assign lk_acc     = lk_valid_i && !busy_q && (lk_bank_i == BANK_ID);
  assign tg_acc     = tg_valid_i && busy_q && !tag_got_q && (tg_id_i == id_q);
  assign kill       = cancel_i && busy_q;
  assign fire       = busy_q && rd_done && tag_got_q && !cancel_i;
  assign lk_ready_o = !busy_q;

  cb_array u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (fill_valid_i),
    .wr_idx_i  (fill_index_i),
    .wr_tag_i  (fill_tag_i),
    .wr_data_i (fill_data_i),
    .rd_idx_i  (idx_q),
    .rd_set_o  (set_rd)
  );

  cb_read_pipe #(.RD_LAT(RD_LAT)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (lk_acc),
    .clear_i (kill || fire),
    .set_i   (set_rd),
    .done_o  (rd_done),
    .ways_o  (ways_q)
  );

  cb_tag_match u_match (
    .ways_i (ways_q),
    .tag_i  (tag_q),
    .hit_o  (mt_hit),
    .way_o  (mt_way),
    .data_o (mt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      tag_got_q   <= 1'b0;
      id_q        <= '0;
      idx_q       <= '0;
      tag_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_id_o    <= '0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (kill) begin
        busy_q    <= 1'b0;
        tag_got_q <= 1'b0;
      end else if (fire) begin
        busy_q      <= 1'b0;
        tag_got_q   <= 1'b0;
        rsp_valid_o <= 1'b1;
        rsp_id_o    <= id_q;
        rsp_hit_o   <= mt_hit;
        rsp_way_o   <= mt_way;
        rsp_data_o  <= mt_data;
      end else if (lk_acc) begin
        busy_q    <= 1'b1;
        tag_got_q <= 1'b0;
        id_q      <= lk_id_i;
        idx_q     <= lk_index_i;
      end else if (tg_acc) begin
        tag_got_q <= 1'b1;
        tag_q     <= tg_tag_i;
      end
    end
  end
endmodule

// File: rtl/cb_bank_chk.sv
module cb_bank_chk
  import cb_pkg::*;
#(
  parameter logic [BANK_W-1:0] BANK_ID = 6'h2A
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [BANK_W-1:0] lk_bank_i,
  input logic              lk_ready_o,
  input logic              cancel_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [WAY_W-1:0]  rsp_way_o,
  input logic [DATA_W-1:0] rsp_data_o
);
  p_foreign_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_ready_o && lk_valid_i && lk_bank_i != BANK_ID) |=> lk_ready_o);

  p_accept_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_ready_o && lk_valid_i && lk_bank_i == BANK_ID) |=> !lk_ready_o);

  p_rsp_after_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!lk_ready_o));

  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_way_o == '0 && rsp_data_o == '0));

  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_ready_in_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> lk_ready_o);

  p_cancel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_i && !lk_ready_o) |=> (lk_ready_o && !rsp_valid_o));
endmodule

bind cb_bank cb_bank_chk #(.BANK_ID(BANK_ID)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_valid_i  (lk_valid_i),
  .lk_bank_i   (lk_bank_i),
  .lk_ready_o  (lk_ready_o),
  .cancel_i    (cancel_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_way_o   (rsp_way_o),
  .rsp_data_o  (rsp_data_o)
);

// File: tb/cb_bank_tb.sv
module cb_bank_tb;
  import cb_pkg::*;

  localparam logic [BANK_W-1:0] BID = 6'h2A;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, tg_valid = 1'b0, cancel = 1'b0, fill_valid = 1'b0;
  logic [BANK_W-1:0] lk_bank = '0;
  logic [IDX_W-1:0]  lk_index = '0, fill_index = '0;
  logic [ID_W-1:0]   lk_id = '0, tg_id = '0;
  logic [TAG_W-1:0]  tg_tag = '0, fill_tag = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic              lk_ready, rsp_valid, rsp_hit;
  logic [ID_W-1:0]   rsp_id;
  logic [WAY_W-1:0]  rsp_way;
  logic [DATA_W-1:0] rsp_data;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cb_bank #(.BANK_ID(BID), .RD_LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_bank_i(lk_bank), .lk_index_i(lk_index), .lk_id_i(lk_id),
    .lk_ready_o(lk_ready),
    .tg_valid_i(tg_valid), .tg_id_i(tg_id), .tg_tag_i(tg_tag),
    .cancel_i(cancel),
    .fill_valid_i(fill_valid), .fill_index_i(fill_index), .fill_tag_i(fill_tag),
    .fill_data_i(fill_data),
    .rsp_valid_o(rsp_valid), .rsp_id_o(rsp_id), .rsp_hit_o(rsp_hit),
    .rsp_way_o(rsp_way), .rsp_data_o(rsp_data)
  );

  // reference model
  bit                m_val  [SETS][WAYS];
  logic [TAG_W-1:0]  m_tag  [SETS][WAYS];
  logic [DATA_W-1:0] m_data [SETS][WAYS];
  int                m_vctr = 0;

  function automatic int m_find(int idx, logic [TAG_W-1:0] t);
    for (int w = 0; w < WAYS; w++) if (m_val[idx][w] && m_tag[idx][w] == t) return w;
    return -1;
  endfunction

  function automatic void m_fill(int idx, logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
    int w;
    w = m_find(idx, t);
    if (w < 0) begin
      w = m_vctr;
      m_vctr = (m_vctr + 1) % WAYS;
    end
    m_val[idx][w] = 1'b1;
    m_tag[idx][w] = t;
    m_data[idx][w] = d;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_check(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (rsp_valid) seen = 1;
    end
    chk(!seen && lk_ready, req, {seen, lk_ready}, 64'h1);
  endtask

  task automatic do_fill(input int idx, input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_index = IDX_W'(idx); fill_tag = t; fill_data = d;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    m_fill(idx, t, d);
  endtask

  // d: edge of tag acceptance; wrong_d: edge with a mismatched ID; fill_d: mid-lookup fill edge
  task automatic do_lookup(input int idx, input logic [ID_W-1:0] id, input logic [TAG_W-1:0] t,
                           input int d, input int wrong_d, input bit poke,
                           input int fill_d, input logic [TAG_W-1:0] ft, input logic [DATA_W-1:0] fd);
    int ew, got;
    logic [DATA_W-1:0] ed;
    ew = m_find(idx, t);
    ed = (ew >= 0) ? m_data[idx][ew] : '0;
    got = -1;
    @(negedge clk);
    lk_valid = 1'b1; lk_bank = BID; lk_index = IDX_W'(idx); lk_id = id;
    for (int c = 0; c < 24 && got < 0; c++) begin
      @(posedge clk); @(negedge clk);
      lk_valid = 1'b0; tg_valid = 1'b0; fill_valid = 1'b0;
      if (rsp_valid) begin
        got = c;
        chk(rsp_hit == (ew >= 0), "R6 hit", rsp_hit, (ew >= 0));
        chk(rsp_way == ((ew >= 0) ? WAY_W'(ew) : '0), "R6/R7 way", rsp_way, (ew >= 0) ? ew : 0);
        chk(rsp_data == ed, "R6/R7 data", rsp_data, ed);
        chk(rsp_id == id, "R6 id", rsp_id, id);
        chk(lk_ready == 1'b1, "R8 ready in rsp cycle", lk_ready, 1);
      end else begin
        if (c + 1 == d) begin
          tg_valid = 1'b1; tg_id = id; tg_tag = t;
        end else if (c + 1 == wrong_d) begin
          tg_valid = 1'b1; tg_id = id ^ ID_W'(1); tg_tag = t;
        end
        if (c + 1 == fill_d) begin
          fill_valid = 1'b1; fill_index = IDX_W'(idx); fill_tag = ft; fill_data = fd;
          m_fill(idx, ft, fd);
        end
        if (poke && c + 1 == 1) begin
          chk(lk_ready == 1'b0, "R3 busy", lk_ready, 0);
          lk_valid = 1'b1; lk_bank = BID; lk_index = IDX_W'(idx + 1); lk_id = id + ID_W'(2);
        end
      end
    end
    chk(got == max2(LAT, d) + 1, "R5 latency", got, max2(LAT, d) + 1);
    idle_check(LAT + 3, "R8 single response");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lk_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset outputs", {lk_ready, rsp_valid}, 64'h2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty array misses
    do_lookup(3, 3'd1, 10'h055, 1, 0, 0, 0, '0, '0);

    // R9: nine allocations wrap the victim counter; refill updates in place
    for (int i = 0; i < 9; i++) do_fill(5, TAG_W'(100 + i), 32'hA000_0000 + i);
    do_lookup(5, 3'd2, TAG_W'(100), 1, 0, 0, 0, '0, '0);       // R9 evicted, miss
    do_lookup(5, 3'd3, TAG_W'(108), LAT, 0, 0, 0, '0, '0);     // R9 way 0, tag on read edge
    do_lookup(5, 3'd4, TAG_W'(107), LAT + 3, 0, 0, 0, '0, '0); // R9 way 7, late tag
    do_fill(5, TAG_W'(103), 32'hBEEF_0003);
    do_fill(5, TAG_W'(200), 32'hBEEF_0200);
    do_lookup(5, 3'd5, TAG_W'(103), 2, 0, 0, 0, '0, '0);       // R9 way 3 updated
    do_lookup(5, 3'd6, TAG_W'(200), 1, 0, 0, 0, '0, '0);       // R9 way 1 allocated

    // R3 busy poke, R4 wrong ID before right one
    do_lookup(5, 3'd2, TAG_W'(104), 4, 2, 1, 0, '0, '0);

    // R12 fill after capture edge is invisible to the held request
    do_lookup(5, 3'd7, TAG_W'(300), LAT + 3, 0, 0, LAT + 1, TAG_W'(300), 32'h1234_5678);
    do_lookup(5, 3'd0, TAG_W'(300), 1, 0, 0, 0, '0, '0);       // R12 now visible

    // R2 foreign bank ignored, then R11 stray tag ignored
    @(negedge clk);
    lk_valid = 1'b1; lk_bank = BID ^ 6'h01; lk_index = 4'd5; lk_id = 3'd1;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    chk(lk_ready == 1'b1, "R2 foreign bank", lk_ready, 1);
    tg_valid = 1'b1; tg_id = 3'd1; tg_tag = TAG_W'(108);
    @(posedge clk); @(negedge clk);
    tg_valid = 1'b0;
    idle_check(LAT + 3, "R2/R11 no response");

    // R10 cancel
    @(negedge clk);
    lk_valid = 1'b1; lk_bank = BID; lk_index = 4'd5; lk_id = 3'd3;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0; cancel = 1'b1;
    @(posedge clk); @(negedge clk);
    cancel = 1'b0;
    chk(lk_ready == 1'b1, "R10 ready after cancel", lk_ready, 1);
    tg_valid = 1'b1; tg_id = 3'd3; tg_tag = TAG_W'(108);
    @(posedge clk); @(negedge clk);
    tg_valid = 1'b0;
    idle_check(LAT + 3, "R10 no response after cancel");

    // random mix
    for (int n = 0; n < 60; n++) begin
      int idx, d;
      logic [TAG_W-1:0] t;
      idx = int'($urandom % 4);
      t = TAG_W'(20 + ($urandom % 12));
      if ($urandom % 3 == 0) begin
        do_fill(idx, t, $urandom);
      end else begin
        d = 1 + int'($urandom % 5);
        do_lookup(idx, ID_W'($urandom), t, d, 0, 0, 0, '0, '0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule